// File: doc/BRIEF.md
# Chroma Transient Improvement Interpolator

This block turns a chroma stream carrying one U/V pair for every four luma slots into a stream with one U/V pair per luma slot. Colour edges come out steeper than the input bandwidth would allow. The conversion has two halves. The first half is a fixed upsampler. It forms a midpoint between neighbouring chroma pairs, which gives twice the chroma rate. It then forms midpoints again at luma resolution. The second half is a steering stage. It reads the upsampled stream out of a tapped line, from a tap that moves away from the centre. How far it moves depends on a signed activity measure taken from the local change in U and V.

Ahead of an edge the measure is positive, so an older tap is read and the pre-edge colour is held for longer. Past the midpoint of the edge the measure turns negative, so a newer tap is read and the post-edge colour arrives early. Three controls shape the move: a gain setting, a maximum reach, and a switch that stops the read from crossing a local peak or valley of U or V. The latency is fixed, so luma can be delayed by a matching amount outside the block.

Top module: `cti_interp`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `u_out` and `v_out` are 0, all held chroma and line taps are cleared, and the phase returns to the key slot.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. In a cycle that follows `in_valid` low, `u_out` and `v_out` keep their values.
- R3: The phase counts `in_valid` cycles modulo 4 from reset. `u_in` and `v_in` are captured only in the slot where the phase is 0, the key slot. Input values in the other slots, or in cycles with `in_valid` low, have no effect on the output.
- R4: The upsampled stream pushed in slot 4n+p uses a = chroma of key slot 4(n-1), b = chroma of key slot 4n, and m = floor((a+b)/2). Both a and b count as 0 when they lie before reset. The values for p = 0, 1, 2, 3 are a, floor((a+m)/2), m and floor((m+b)/2).
- R5: When the gain code is 00, the output registered in slot s equals the upsampled value pushed in slot s-13. That value is the interpolated position s-17.
- R6: Let tap j hold the value pushed j+1 slots ago, with centre tap 12. The measure is D = (|u11-u12|+|v11-v12|) - (|u12-u13|+|v12-v13|). The shift is k = floor((D + 2^(t-1)) / 2^t), with t = 3 + g. The output is tap 12+k, so a positive k reads an older sample.
- R7: The gain code 00 forces k = 0. Codes 01, 10 and 11 select g = 2, 1 and 0, which are gains of 1/4, 1/2 and 1.
- R8: k saturates to ±12, ±8, ±6 or ±4 for range codes 00, 01, 10 and 11.
- R9: With `hill_en` high, tap i (1..23) is marked when it is a strict local maximum or minimum of U or of V against taps i-1 and i+1. A positive k is cut to the distance from the centre to the nearest marked tap among 13..23. A negative k is cut the same way using the nearest marked tap among 11..1. When no tap is marked, the limit is 12.
- R10: With `hill_en` low, no mark limits k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Luma-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One luma slot is present |
| u_in | input | 8 | Signed U sample, used in key slots |
| v_in | input | 8 | Signed V sample, used in key slots |
| range_sel | input | 2 | Maximum steering reach code |
| gain_sel | input | 2 | Steering gain code |
| hill_en | input | 1 | Enables the peak/valley limit |
| out_valid | output | 1 | Output slot is present |
| u_out | output | 8 | Signed U at luma resolution |
| v_out | output | 8 | Signed V at luma resolution |

## Verification
Every output belongs to the `in_valid` edge that produced it and is readable during the following cycle. For slot s, the value read from tap 12+k is the upsampled value from slot s-13-k, which is interpolated position s-17-k. The bench keeps its own slot counter, separate from the cycle count. It rebuilds the upsampled stream from the key samples alone and compares each result one time unit after the edge that registered it. Idle cycles are placed between slots. The output is checked in each idle cycle against the value from the cycle before, which confirms that neither the timing nor the stream moves.

// File: rtl/cti_pkg.sv
package cti_pkg;

    typedef enum logic [1:0] {
        ST_KEY  = 2'd0,
        ST_QTR  = 2'd1,
        ST_MID  = 2'd2,
        ST_3QTR = 2'd3
    } phase_e;

    function automatic int span_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 12;
            2'd1:    return 8;
            2'd2:    return 6;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/cti_upsample.sv
module cti_upsample
    import cti_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic signed [W-1:0] u_in,
    input  logic signed [W-1:0] v_in,
    output phase_e              phase,
    output logic signed [W-1:0] fill_u,
    output logic signed [W-1:0] fill_v
);

    phase_e phase_q, phase_d;
    logic signed [W-1:0] u_prev, u_cur, v_prev, v_cur;

    function automatic logic signed [W-1:0] avg2(input logic signed [W-1:0] a,
                                                 input logic signed [W-1:0] b);
        logic [W:0] s;
        s = {a[W-1], a} + {b[W-1], b};
        return s[W:1];
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= ST_KEY;
        else        phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        if (step) begin
            unique case (phase_q)
                ST_KEY:  phase_d = ST_QTR;
                ST_QTR:  phase_d = ST_MID;
                ST_MID:  phase_d = ST_3QTR;
                ST_3QTR: phase_d = ST_KEY;
            endcase
        end
    end

    // held chroma pair, loaded in the key slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            u_prev <= '0;
            u_cur  <= '0;
            v_prev <= '0;
            v_cur  <= '0;
        end else if (step && phase_q == ST_KEY) begin
            u_prev <= u_cur;
            u_cur  <= u_in;
            v_prev <= v_cur;
            v_cur  <= v_in;
        end
    end

    // outputs per state
    always_comb begin
        unique case (phase_q)
            ST_KEY: begin
                fill_u = u_cur;
                fill_v = v_cur;
            end
            ST_QTR: begin
                fill_u = avg2(u_prev, avg2(u_prev, u_cur));
                fill_v = avg2(v_prev, avg2(v_prev, v_cur));
            end
            ST_MID: begin
                fill_u = avg2(u_prev, u_cur);
                fill_v = avg2(v_prev, v_cur);
            end
            ST_3QTR: begin
                fill_u = avg2(avg2(u_prev, u_cur), u_cur);
                fill_v = avg2(avg2(v_prev, v_cur), v_cur);
            end
        endcase
    end

    assign phase = phase_q;

endmodule

// File: rtl/cti_tapline.sv
module cti_tapline #(
    parameter int W     = 8,
    parameter int DEPTH = 25
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift,
    input  logic signed [W-1:0] din_u,
    input  logic signed [W-1:0] din_v,
    output logic signed [W-1:0] tap_u [DEPTH],
    output logic signed [W-1:0] tap_v [DEPTH]
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tap_u[i] <= '0;
                tap_v[i] <= '0;
            end
        end else if (shift) begin
            tap_u[0] <= din_u;
            tap_v[0] <= din_v;
            for (int i = 1; i < DEPTH; i++) begin
                tap_u[i] <= tap_u[i-1];
                tap_v[i] <= tap_v[i-1];
            end
        end
    end

endmodule

// File: rtl/cti_steer.sv
module cti_steer
    import cti_pkg::*;
#(
    parameter int W        = 8,
    parameter int HALF     = 12,
    parameter int SCALE_SH = 3,
    parameter int DEPTH    = 2 * HALF + 1,
    parameter int KW       = $clog2(HALF + 1) + 1
) (
    input  logic signed [W-1:0]  tap_u [DEPTH],
    input  logic signed [W-1:0]  tap_v [DEPTH],
    input  logic [1:0]           gain_sel,
    input  logic [1:0]           range_sel,
    input  logic                 hill_en,
    output logic signed [KW-1:0] shift_k
);

    localparam int DW = W + 3;

    function automatic logic [W:0] mag(input logic signed [W-1:0] a,
                                       input logic signed [W-1:0] b);
        logic [W:0] d;
        d = {a[W-1], a} - {b[W-1], b};
        return d[W] ? -d : d;
    endfunction

    function automatic logic peak(input logic signed [W-1:0] a,
                                  input logic signed [W-1:0] m,
                                  input logic signed [W-1:0] b);
        return (m > a && m > b) || (m < a && m < b);
    endfunction

    logic [DW-1:0]        act_new, act_old;
    logic signed [DW-1:0] meas;
    logic signed [DW:0]   biased, scaled;
    logic                 mark [DEPTH];
    int                   sh_i, want_k, span_i, lim_p, lim_n, kk;

    assign act_new = DW'(mag(tap_u[HALF-1], tap_u[HALF])) + DW'(mag(tap_v[HALF-1], tap_v[HALF]));
    assign act_old = DW'(mag(tap_u[HALF], tap_u[HALF+1])) + DW'(mag(tap_v[HALF], tap_v[HALF+1]));
    assign meas    = $signed(act_new) - $signed(act_old);

    assign mark[0]       = 1'b0;
    assign mark[DEPTH-1] = 1'b0;
    for (genvar i = 1; i < DEPTH - 1; i++) begin : g_mark
        assign mark[i] = peak(tap_u[i-1], tap_u[i], tap_u[i+1])
                       | peak(tap_v[i-1], tap_v[i], tap_v[i+1]);
    end

    always_comb begin
        case (gain_sel)
            2'd1:    sh_i = SCALE_SH + 2;
            2'd2:    sh_i = SCALE_SH + 1;
            default: sh_i = SCALE_SH;
        endcase
        biased = {meas[DW-1], meas} + ((DW+1)'(1) << (sh_i - 1));
        scaled = biased >>> sh_i;
        want_k = (gain_sel == 2'd0) ? 0 : int'(scaled);

        span_i = span_of(range_sel);
        kk = want_k;
        if (kk > span_i)  kk = span_i;
        if (kk < -span_i) kk = -span_i;

        lim_p = HALF;
        lim_n = HALF;
        for (int j = HALF - 1; j >= 1; j--) begin
            if (mark[HALF+j]) lim_p = j;
            if (mark[HALF-j]) lim_n = j;
        end
        if (hill_en) begin
            if (kk > lim_p)  kk = lim_p;
            if (kk < -lim_n) kk = -lim_n;
        end
    end

    assign shift_k = KW'(kk);

endmodule

// File: rtl/cti_interp.sv
module cti_interp
    import cti_pkg::*;
#(
    parameter int W        = 8,
    parameter int HALF     = 12,
    parameter int SCALE_SH = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] u_in,
    input  logic signed [W-1:0] v_in,
    input  logic [1:0]          range_sel,
    input  logic [1:0]          gain_sel,
    input  logic                hill_en,
    output logic                out_valid,
    output logic signed [W-1:0] u_out,
    output logic signed [W-1:0] v_out
);

    localparam int DEPTH = 2 * HALF + 1;
    localparam int KW    = $clog2(HALF + 1) + 1;
    localparam int IW    = $clog2(DEPTH);

    phase_e               fill_phase;
    logic signed [W-1:0]  fill_u, fill_v;
    logic signed [W-1:0]  tap_u [DEPTH];
    logic signed [W-1:0]  tap_v [DEPTH];
    logic signed [KW-1:0] shift_k;
    logic signed [W-1:0]  mid_u, mid_v;
    logic [IW-1:0]        pick;

    cti_upsample #(.W(W)) u_up (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (in_valid),
        .u_in   (u_in),
        .v_in   (v_in),
        .phase  (fill_phase),
        .fill_u (fill_u),
        .fill_v (fill_v)
    );

    cti_tapline #(.W(W), .DEPTH(DEPTH)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (in_valid),
        .din_u (fill_u),
        .din_v (fill_v),
        .tap_u (tap_u),
        .tap_v (tap_v)
    );

    cti_steer #(.W(W), .HALF(HALF), .SCALE_SH(SCALE_SH), .DEPTH(DEPTH), .KW(KW)) u_steer (
        .tap_u     (tap_u),
        .tap_v     (tap_v),
        .gain_sel  (gain_sel),
        .range_sel (range_sel),
        .hill_en   (hill_en),
        .shift_k   (shift_k)
    );

    assign mid_u = tap_u[HALF];
    assign mid_v = tap_v[HALF];
    assign pick  = IW'(HALF + int'(shift_k));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            u_out     <= '0;
            v_out     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                u_out <= tap_u[pick];
                v_out <= tap_v[pick];
            end
        end
    end

endmodule

// File: rtl/cti_interp_chk.sv
module cti_interp_chk
    import cti_pkg::*;
#(
    parameter int W  = 8,
    parameter int KW = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [1:0]          gain_sel,
    input logic [1:0]          range_sel,
    input logic                out_valid,
    input logic signed [W-1:0] u_out,
    input logic signed [W-1:0] v_out,
    input logic signed [KW-1:0] shift_k,
    input logic signed [W-1:0] mid_u,
    input logic signed [W-1:0] mid_v,
    input phase_e              phase
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(u_out) && $stable(v_out))); // R2
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && phase == ST_3QTR) |=> phase == ST_KEY); // R3
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(phase)); // R3
    AST_ZERO_GAIN_CENTRE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && gain_sel == 2'd0) |=> (u_out == $past(mid_u) && v_out == $past(mid_v))); // R5
    AST_SPAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(shift_k) <= span_of(range_sel) && int'(shift_k) >= -span_of(range_sel))); // R8

endmodule

bind cti_interp cti_interp_chk #(.W(W), .KW(KW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .gain_sel  (gain_sel),
    .range_sel (range_sel),
    .out_valid (out_valid),
    .u_out     (u_out),
    .v_out     (v_out),
    .shift_k   (shift_k),
    .mid_u     (mid_u),
    .mid_v     (mid_v),
    .phase     (fill_phase)
);

// File: tb/tb_cti_interp.sv
module tb_cti_interp;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int HALF       = 12;
    localparam int SCALE_SH   = 3;
    localparam int NCH        = 24;
    localparam int NS         = NCH * 4;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic signed [W-1:0] u_in, v_in;
    logic [1:0] range_sel, gain_sel;
    logic hill_en;
    logic out_valid;
    logic signed [W-1:0] u_out, v_out;

    int n_vec = 0;
    int n_bad = 0;
    int pattern;
    int cu [NCH];
    int cv [NCH];
    int pu [NS];
    int pv [NS];

    always #(CLK_PERIOD/2) clk = ~clk;

    cti_interp #(.W(W), .HALF(HALF), .SCALE_SH(SCALE_SH)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .u_in(u_in), .v_in(v_in),
        .range_sel(range_sel), .gain_sel(gain_sel), .hill_en(hill_en),
        .out_valid(out_valid), .u_out(u_out), .v_out(v_out)
    );

    function automatic int iabs(int a); return (a < 0) ? -a : a; endfunction
    function automatic int avg(int a, int b); return (a + b) >>> 1; endfunction
    function automatic int xu(int s, int j); return (s - 1 - j >= 0) ? pu[s-1-j] : 0; endfunction
    function automatic int xv(int s, int j); return (s - 1 - j >= 0) ? pv[s-1-j] : 0; endfunction

    function automatic bit ext(int a, int m, int b);
        return (m > a && m > b) || (m < a && m < b);
    endfunction

    function automatic bit is_mark(int s, int i);
        return ext(xu(s, i-1), xu(s, i), xu(s, i+1)) || ext(xv(s, i-1), xv(s, i), xv(s, i+1));
    endfunction

    task automatic build_stream();
        for (int t = 0; t < NS; t++) begin
            int n, p, au, bu, av, bv, mu, mv;
            n = t / 4; p = t % 4;
            au = (n > 0) ? cu[n-1] : 0; bu = cu[n];
            av = (n > 0) ? cv[n-1] : 0; bv = cv[n];
            mu = avg(au, bu); mv = avg(av, bv);
            case (p)
                0: begin pu[t] = au; pv[t] = av; end
                1: begin pu[t] = avg(au, mu); pv[t] = avg(av, mv); end
                2: begin pu[t] = mu; pv[t] = mv; end
                default: begin pu[t] = avg(mu, bu); pv[t] = avg(mv, bv); end
            endcase
        end
    endtask

    task automatic model(input int s, output int eu, output int ev, output string tag);
        int dn, dold, m, raw, sh, span, k, lp, ln;
        dn   = iabs(xu(s, HALF-1) - xu(s, HALF)) + iabs(xv(s, HALF-1) - xv(s, HALF));
        dold = iabs(xu(s, HALF) - xu(s, HALF+1)) + iabs(xv(s, HALF) - xv(s, HALF+1));
        m = dn - dold;
        if (gain_sel == 2'd0) raw = 0;
        else begin
            sh  = SCALE_SH + ((gain_sel == 2'd1) ? 2 : (gain_sel == 2'd2) ? 1 : 0);
            raw = (m + (1 << (sh - 1))) >>> sh;
        end
        span = (range_sel == 2'd0) ? 12 : (range_sel == 2'd1) ? 8 : (range_sel == 2'd2) ? 6 : 4;
        k = raw;
        if (k > span)  k = span;
        if (k < -span) k = -span;
        lp = HALF; ln = HALF;
        for (int j = HALF - 1; j >= 1; j--) begin
            if (is_mark(s, HALF + j)) lp = j;
            if (is_mark(s, HALF - j)) ln = j;
        end
        if (gain_sel == 2'd0)                      tag = (pattern == 0) ? "R4" : "R5";
        else if (hill_en && (k > lp || -k > ln))   tag = "R9";
        else if (!hill_en && (k > lp || -k > ln))  tag = "R10";
        else if (iabs(raw) > span)                 tag = "R8";
        else if (pattern == 2)                     tag = "R3";
        else if (gain_sel != 2'd3)                 tag = "R7";
        else                                       tag = "R6";
        if (hill_en) begin
            if (k > lp)  k = lp;
            if (k < -ln) k = -ln;
        end
        eu = xu(s, HALF + k);
        ev = xv(s, HALF + k);
    endtask

    task automatic check(input string tag, input int au, input int av, input int eu, input int ev);
        n_vec++;
        if (au != eu || av != ev) begin
            n_bad++;
            $display("FAIL %s pat=%0d g=%0d r=%0d h=%0d actual=%0d/%0d expected=%0d/%0d",
                     tag, pattern, gain_sel, range_sel, hill_en, au, av, eu, ev);
        end
    endtask

    task automatic load_pattern(input int pat);
        for (int n = 0; n < NCH; n++) begin
            case (pat)
                0: begin cu[n] = (n < 12) ? -60 : 90; cv[n] = (n < 12) ? 40 : -70; end
                1: begin cu[n] = (n >= 10 && n < 13) ? 100 : -20; cv[n] = (n == 11) ? 30 : 0; end
                2: begin cu[n] = int'($urandom_range(255)) - 128; cv[n] = int'($urandom_range(255)) - 128; end
                default: begin cu[n] = (n == 11) ? 120 : 0; cv[n] = (n % 2 == 1) ? 127 : -128; end
            endcase
        end
    endtask

    task automatic run_case(input int pat, input int g, input int r, input int h);
        int eu, ev, lu, lv;
        string tag;
        pattern = pat;
        load_pattern(pat);
        build_stream();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; u_in = '0; v_in = '0;
        gain_sel = 2'(g); range_sel = 2'(r); hill_en = 1'(h);
        @(posedge clk); #1;
        check("R1", int'(u_out) + (out_valid ? 1000 : 0), int'(v_out), 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < NS; s++) begin
            if (s % 7 == 3) begin
                lu = int'(u_out); lv = int'(v_out);
                @(negedge clk);
                in_valid = 1'b0; u_in = W'($urandom); v_in = W'($urandom);
                @(posedge clk); #1;
                check("R2", int'(u_out) + (out_valid ? 1000 : 0), int'(v_out), lu, lv);
            end
            @(negedge clk);
            in_valid = 1'b1;
            if (s % 4 == 0) begin u_in = W'(cu[s/4]); v_in = W'(cv[s/4]); end
            else            begin u_in = W'($urandom); v_in = W'($urandom); end
            @(posedge clk); #1;
            model(s, eu, ev, tag);
            check("R2", out_valid ? 1 : 0, 0, 1, 0);
            check(tag, int'(u_out), int'(v_out), eu, ev);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; u_in = '0; v_in = '0;
        gain_sel = '0; range_sel = '0; hill_en = 1'b0;
        for (int pat = 0; pat < 4; pat++)
            for (int g = 0; g < 4; g++)
                for (int r = 0; r < 4; r++)
                    for (int h = 0; h < 2; h++)
                        run_case(pat, g, r, h);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule